// File: doc/BRIEF.md
# I2C Master Read Sequencer

This block drives the receive side of an I2C master read at byte level. On a start request it issues a START, sends the target address with the read bit set, then requests data bytes one at a time from a byte-level bus engine. For each byte it decides whether to acknowledge or not, and it ends every transfer with a STOP. The bus engine sits outside this block. It takes one command at a time (`cmd_valid_o` pulse) and answers each command with exactly one completion event that carries a status code and, for reads, the received byte.

An optional header mode treats the first received byte as a length prefix. If that value is within the limit, it is added to the number of bytes still to read. Each completion status is classified into a 3-bit error code. The first error stops the transfer: a STOP is issued, and a one-cycle done pulse reports the number of bytes received and the error code.

Top module: `i2c_rd_seq`

## Requirements
- R1: A start request with length 0 issues no bus command. One cycle after the request, `done_o` pulses with count 0 and error code 4 (unsupported).
- R2: A transfer with a non-zero length issues its commands in this order: START (op 0), SEND (op 1) with byte `{addr_i, 1'b1}`, zero or more RECV (op 2), and finally STOP (op 3). The STOP is issued in every case, including after an error.
- R3: Every RECV has `cmd_ack_o` = 1 except the one for the last byte of the transfer, which has `cmd_ack_o` = 0.
- R4: When `blk_i` was set at start, the first RECV always has `cmd_ack_o` = 1, even when the length is 1. The first byte received is then added to the remaining count, as long as it is no larger than BLK_MAX (default 32).
- R5: In header mode, a first byte larger than BLK_MAX ends the transfer with error code 5 (protocol). No further RECV is issued.
- R6: The completion status 8'h50 (byte received, acknowledged) on the last byte is error code 1 (I/O). The status 8'h58 (byte received, not acknowledged) on any byte other than the last is also error code 1.
- R7: The address status 8'h48 (address not acknowledged) gives error code 2 (no device).
- R8: The arbitration-lost statuses 8'h38, 8'h68, 8'h78 and 8'h B0 give error code 3 (retry). A START completion whose status is neither 8'h08 nor 8'h10 also gives error code 3.
- R9: The statuses that mean this device is being addressed as a target (8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0, 8'hA8, 8'hC0, 8'hC8) give error code 4 (unsupported).
- R10: Each RECV completion produces a one-cycle `rx_valid_o` with the byte. The STOP completion produces a one-cycle `done_o`, with `done_cnt_o` equal to the number of bytes received and `done_err_o` holding the first error (0 when there is none). `busy_o` is low while `done_o` is high.
- R11: At most one command is outstanding. After a `cmd_valid_o` pulse, no new command is issued until the completion event for that command has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| addr_i | input | 7 | Target address |
| len_i | input | LEN_W | Number of bytes to read |
| blk_i | input | 1 | First byte is a length prefix |
| cmd_valid_o | output | 1 | One-cycle command strobe to the bus engine |
| cmd_op_o | output | 2 | Command: 0 START, 1 SEND, 2 RECV, 3 STOP |
| cmd_byte_o | output | 8 | Byte to send (SEND only, otherwise 0) |
| cmd_ack_o | output | 1 | Acknowledge the byte being received (RECV only) |
| evt_valid_i | input | 1 | Completion event from the bus engine |
| evt_stat_i | input | 8 | Completion status code |
| evt_data_i | input | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| done_o | output | 1 | Transfer finished pulse |
| done_cnt_o | output | CNT_W | Bytes received in the transfer |
| done_err_o | output | 3 | Error code: 0 ok, 1 I/O, 2 no device, 3 retry, 4 unsupported, 5 protocol |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions rely on three conditions on the inputs. The bus engine raises `evt_valid_i` only while a command is outstanding, and only once per command. `start_i` is asserted only while `busy_o` is low. Under these conditions, the count of remaining bytes can be extended only once per transfer. The bench respects all three: a responder answers each observed command exactly once, after a fixed delay of one or more cycles. The bench also pulses the start request only after the previous done pulse has been seen.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3} op_e;
  typedef enum logic [2:0] {
    E_OK = 3'd0, E_IO = 3'd1, E_NODEV = 3'd2, E_RETRY = 3'd3, E_UNSUPP = 3'd4, E_PROTO = 3'd5
  } err_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ISSUE = 2'd1, S_WAIT = 2'd2} st_e;
endpackage

// File: rtl/i2c_rd_classify.sv
module i2c_rd_classify
  import i2c_rd_pkg::*;
(
  input  op_e        phase_i,
  input  logic [7:0] stat_i,
  input  logic       last_i,
  output err_e       err_o
);
  always_comb begin
    err_o = E_IO;
    if (phase_i == OP_START) begin
      err_o = (stat_i == 8'h08 || stat_i == 8'h10) ? E_OK : E_RETRY;
    end else if (phase_i == OP_STOP) begin
      err_o = E_OK;
    end else begin
      case (stat_i)
        8'hF8, 8'h40, 8'h18, 8'h28:        err_o = E_OK;
        8'h50:                             err_o = last_i ? E_IO : E_OK;
        8'h58:                             err_o = last_i ? E_OK : E_IO;
        8'h48, 8'h20:                      err_o = E_NODEV;
        8'h38, 8'h68, 8'h78, 8'hB0:        err_o = E_RETRY;
        8'h60, 8'h70, 8'h80, 8'h88, 8'h90,
        8'h98, 8'hA0, 8'hA8, 8'hC0, 8'hC8: err_o = E_UNSUPP;
        default:                           err_o = E_IO;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_count.sv
module i2c_rd_count #(
  parameter int LEN_W   = 4,
  parameter int BLK_MAX = 32,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  input  logic             add_en_i,
  input  logic [7:0]       add_val_i,
  output logic [CNT_W-1:0] rem_o,
  output logic [CNT_W-1:0] rem_nxt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int MAX_TOTAL = (1 << LEN_W) - 1 + BLK_MAX;

  logic [CNT_W-1:0] rem_q, rem_d, cnt_q, cnt_d, add_w;
  logic             en;

  always_comb begin
    add_w     = add_en_i ? CNT_W'(add_val_i) : '0;
    rem_nxt_o = rem_q - CNT_W'(1) + add_w;
    en        = load_i | step_i;
    rem_d     = load_i ? CNT_W'(len_i) : rem_nxt_o;
    cnt_d     = load_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign rem_o = rem_q;
  assign cnt_o = cnt_q;

  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rem_q) <= MAX_TOTAL);
endmodule

// File: rtl/i2c_rd_seq.sv
module i2c_rd_seq
  import i2c_rd_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int BLK_MAX = 32,
  localparam int CNT_W  = $clog2((1 << LEN_W) + BLK_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [6:0]       addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             blk_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [7:0]       cmd_byte_o,
  output logic             cmd_ack_o,
  input  logic             evt_valid_i,
  input  logic [7:0]       evt_stat_i,
  input  logic [7:0]       evt_data_i,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic             done_o,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic [2:0]       done_err_o,
  output logic             busy_o
);
  localparam logic [7:0] BLK_LIM = 8'(BLK_MAX);

  // reset: asserted asynchronously, released on the clock
  logic rs_a, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_n <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_n <= rs_a;
    end
  end

  st_e  st_q, st_d;
  op_e  ph_q, ph_d;
  err_e err_q, err_d, cls_err;
  logic first_q, first_d, done_q, done_d, rxv_q, rxv_d;
  logic blk_q;
  logic [6:0] addr_q;
  logic [7:0] rxd_q;
  logic [CNT_W-1:0] rem_w, rem_nxt_w, cnt_w;

  logic start_go, evt_hit, data_hit, hdr, too_big, add_en, last_w;

  always_comb begin
    start_go = (st_q == S_IDLE) && start_i;
    evt_hit  = (st_q == S_WAIT) && evt_valid_i;
    data_hit = evt_hit && (ph_q == OP_RECV);
    hdr      = blk_q && first_q;
    too_big  = hdr && (evt_data_i > BLK_LIM);
    add_en   = data_hit && hdr && !too_big;
    last_w   = (rem_w == CNT_W'(1)) && !hdr;
  end

  i2c_rd_classify u_cls (
    .phase_i (ph_q),
    .stat_i  (evt_stat_i),
    .last_i  ((ph_q == OP_RECV) && last_w),
    .err_o   (cls_err)
  );

  i2c_rd_count #(.LEN_W(LEN_W), .BLK_MAX(BLK_MAX), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rs_n),
    .load_i    (start_go),
    .len_i     (len_i),
    .step_i    (data_hit),
    .add_en_i  (add_en),
    .add_val_i (evt_data_i),
    .rem_o     (rem_w),
    .rem_nxt_o (rem_nxt_w),
    .cnt_o     (cnt_w)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    err_d   = err_q;
    first_d = first_q;
    done_d  = 1'b0;
    rxv_d   = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        first_d = 1'b1;
        if (len_i == '0) begin
          err_d  = E_UNSUPP;
          done_d = 1'b1;
        end else begin
          err_d = E_OK;
          st_d  = S_ISSUE;
          ph_d  = OP_START;
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: if (evt_valid_i) begin
        st_d = S_ISSUE;
        case (ph_q)
          OP_START, OP_SEND: begin
            if (cls_err != E_OK) begin
              err_d = cls_err;
              ph_d  = OP_STOP;
            end else begin
              ph_d = (ph_q == OP_START) ? OP_SEND : OP_RECV;
            end
          end
          OP_RECV: begin
            rxv_d   = 1'b1;
            first_d = 1'b0;
            if (too_big) begin
              err_d = E_PROTO;
              ph_d  = OP_STOP;
            end else if (cls_err != E_OK) begin
              err_d = cls_err;
              ph_d  = OP_STOP;
            end else if (rem_nxt_w == '0) begin
              ph_d = OP_STOP;
            end
          end
          default: begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end
        endcase
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q    <= S_IDLE;
      ph_q    <= OP_START;
      err_q   <= E_OK;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      err_q   <= err_d;
      first_q <= first_d;
      done_q  <= done_d;
      rxv_q   <= rxv_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      addr_q <= '0;
      blk_q  <= 1'b0;
    end else if (start_go) begin
      addr_q <= addr_i;
      blk_q  <= blk_i;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) rxd_q <= '0;
    else if (data_hit) rxd_q <= evt_data_i;
  end

  assign cmd_valid_o = (st_q == S_ISSUE);
  assign cmd_op_o    = ph_q;
  assign cmd_byte_o  = (ph_q == OP_SEND) ? {addr_q, 1'b1} : 8'h00;
  assign cmd_ack_o   = (ph_q == OP_RECV) && !last_w;
  assign rx_valid_o  = rxv_q;
  assign rx_data_o   = rxd_q;
  assign done_o      = done_q;
  assign done_cnt_o  = cnt_w;
  assign done_err_o  = err_q;
  assign busy_o      = (st_q != S_IDLE);

  a_r11_single_cmd: assert property (@(posedge clk) disable iff (!rs_n)
    cmd_valid_o |=> !cmd_valid_o);
  a_r2_read_bit: assert property (@(posedge clk) disable iff (!rs_n)
    (cmd_valid_o && cmd_op_o == 2'd1) |-> cmd_byte_o[0]);
  a_r1_zero_len: assert property (@(posedge clk) disable iff (!rs_n)
    (!busy_o && start_i && len_i == '0) |=> (done_o && done_err_o == 3'd4));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rs_n)
    done_o |-> !busy_o);
  a_r4_first_ack: assert property (@(posedge clk) disable iff (!rs_n)
    (cmd_valid_o && cmd_op_o == 2'd2 && blk_q && first_q) |-> cmd_ack_o);
endmodule

// File: tb/sim_i2c_rd_seq.sv
module sim_i2c_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 4;
  localparam int CNT_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, blk_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic evt_valid_i = 1'b0;
  logic [7:0] evt_stat_i = '0, evt_data_i = '0;
  logic cmd_valid_o, cmd_ack_o, rx_valid_o, done_o, busy_o;
  logic [1:0] cmd_op_o;
  logic [7:0] cmd_byte_o, rx_data_o;
  logic [CNT_W-1:0] done_cnt_o;
  logic [2:0] done_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rd_seq #(.LEN_W(LEN_W), .BLK_MAX(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .blk_i(blk_i), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_byte_o(cmd_byte_o), .cmd_ack_o(cmd_ack_o), .evt_valid_i(evt_valid_i),
    .evt_stat_i(evt_stat_i), .evt_data_i(evt_data_i), .rx_valid_o(rx_valid_o),
    .rx_data_o(rx_data_o), .done_o(done_o), .done_cnt_o(done_cnt_o),
    .done_err_o(done_err_o), .busy_o(busy_o)
  );

  int nchk = 0, nerr = 0;
  int rsp_start, rsp_addr, di, dly, pend, pend_op;
  int rsp_dat[64], rsp_st[64];
  logic [10:0] exp_cmd[$];
  int exp_rx[$];
  int exp_cnt, exp_err;
  bit done_seen, outstanding;
  string exp_tag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // error code expected for a status, from the requirement list
  function automatic int bcls(int s, bit last);
    if (s == 'hF8 || s == 'h40 || s == 'h18 || s == 'h28) return 0;
    if (s == 'h50) return last ? 1 : 0;
    if (s == 'h58) return last ? 0 : 1;
    if (s == 'h48 || s == 'h20) return 2;
    if (s == 'h38 || s == 'h68 || s == 'h78 || s == 'hB0) return 3;
    if (s inside {'h60, 'h70, 'h80, 'h88, 'h90, 'h98, 'hA0, 'hA8, 'hC0, 'hC8}) return 4;
    return 1;
  endfunction

  task automatic model(int a, int l, bit b);
    int rem, i, d;
    bit first, fin;
    exp_cmd.delete(); exp_rx.delete();
    exp_cnt = 0; exp_err = 0;
    if (l == 0) begin exp_err = 4; return; end
    exp_cmd.push_back({2'd0, 8'd0, 1'b0});
    if (!(rsp_start == 'h08 || rsp_start == 'h10)) exp_err = 3;
    else begin
      exp_cmd.push_back({2'd1, 8'((a << 1) | 1), 1'b0});
      exp_err = bcls(rsp_addr, 1'b0);
      rem = l; first = 1'b1; i = 0;
      while (rem > 0 && exp_err == 0) begin
        fin = (rem == 1) && !(b && first);
        exp_cmd.push_back({2'd2, 8'd0, !fin});
        d = rsp_dat[i];
        exp_rx.push_back(d);
        exp_cnt++;
        if (b && first) begin
          if (d > 32) exp_err = 5;
          else rem += d;
        end
        if (exp_err == 0) exp_err = bcls(rsp_st[i], fin);
        rem--; first = 1'b0; i++;
      end
    end
    exp_cmd.push_back({2'd3, 8'd0, 1'b0});
  endtask

  // per-clock monitor and bus-engine responder
  always @(negedge clk) begin
    if (rst_n) begin
      evt_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          evt_valid_i = 1'b1;
          evt_data_i  = 8'h00;
          case (pend_op)
            0: evt_stat_i = 8'(rsp_start);
            1: evt_stat_i = 8'(rsp_addr);
            2: begin evt_stat_i = 8'(rsp_st[di]); evt_data_i = 8'(rsp_dat[di]); di++; end
            default: evt_stat_i = 8'hF8;
          endcase
          outstanding = 1'b0;
        end
      end
      if (cmd_valid_o) begin
        logic [10:0] got, e;
        chk(!outstanding, "R11", "command while one outstanding", 1, 0);
        got = {cmd_op_o, cmd_byte_o, cmd_ack_o};
        if (exp_cmd.size() == 0) chk(1'b0, exp_tag, "unexpected command op", int'(cmd_op_o), -1);
        else begin
          e = exp_cmd.pop_front();
          chk(got == e, (cmd_op_o == 2'd2) ? "R3" : "R2", "command {op,byte,ack}", int'(got), int'(e));
        end
        outstanding = 1'b1;
        pend = dly;
        pend_op = int'(cmd_op_o);
      end
      if (rx_valid_o) begin
        if (exp_rx.size() == 0) chk(1'b0, "R10", "unexpected rx byte", int'(rx_data_o), -1);
        else begin
          int e;
          e = exp_rx.pop_front();
          chk(int'(rx_data_o) == e, "R10", "rx byte", int'(rx_data_o), e);
        end
      end
      if (done_o) begin
        chk(int'(done_err_o) == exp_err, exp_tag, "done error code", int'(done_err_o), exp_err);
        chk(int'(done_cnt_o) == exp_cnt, "R10", "done byte count", int'(done_cnt_o), exp_cnt);
        chk(!busy_o, "R10", "busy during done", int'(busy_o), 0);
        done_seen = 1'b1;
      end
    end
  end

  task automatic run(int a, int l, bit b, int d, string tag);
    int w;
    exp_tag = tag; dly = d; di = 0; done_seen = 1'b0;
    model(a, l, b);
    @(negedge clk);
    addr_i = 7'(a); len_i = LEN_W'(l); blk_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    w = 0;
    while (!done_seen && w < 2000) begin @(negedge clk); w++; end
    chk(done_seen, tag, "done seen", int'(done_seen), 1);
    chk(exp_cmd.size() == 0, tag, "commands left", exp_cmd.size(), 0);
    chk(exp_rx.size() == 0, "R10", "rx bytes left", exp_rx.size(), 0);
    @(negedge clk);
    chk(!done_o, "R10", "done one cycle", int'(done_o), 0);
  endtask

  task automatic okfill(int n);
    for (int i = 0; i < 64; i++) begin rsp_dat[i] = (i * 37 + 5) & 8'hFF; rsp_st[i] = 'h50; end
    rsp_st[n-1] = 'h58;
    rsp_start = 'h08; rsp_addr = 'h40;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(1'b0, "R10", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    pend = 0; outstanding = 1'b0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cmd_valid_o && !done_o && !busy_o && !rx_valid_o, "R10", "reset state", int'(busy_o), 0);

    okfill(1); run('h21, 0, 1'b0, 1, "R1");
    okfill(3); run('h50, 3, 1'b0, 2, "R2");
    okfill(1); run('h7F, 1, 1'b0, 1, "R3");
    okfill(3); rsp_dat[0] = 2; run('h11, 1, 1'b1, 3, "R4");
    okfill(1); rsp_dat[0] = 0; rsp_st[0] = 'h50; run('h12, 1, 1'b1, 1, "R4");
    okfill(2); rsp_dat[0] = 33; run('h13, 2, 1'b1, 2, "R5");
    okfill(33); rsp_dat[0] = 32; run('h14, 1, 1'b1, 1, "R4");
    okfill(2); rsp_addr = 'h48; run('h15, 2, 1'b0, 2, "R7");
    okfill(2); rsp_st[1] = 'h50; run('h16, 2, 1'b0, 1, "R6");
    okfill(3); rsp_st[0] = 'h58; run('h17, 3, 1'b0, 2, "R6");
    okfill(3); rsp_st[1] = 'h38; run('h18, 3, 1'b0, 1, "R8");
    okfill(2); rsp_start = 'h00; run('h19, 2, 1'b0, 2, "R8");
    okfill(2); rsp_addr = 'h60; run('h1A, 2, 1'b0, 1, "R9");
    okfill(4); rsp_start = 'h10; run('h1B, 4, 1'b0, 3, "R2");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule